// File: doc/BRIEF.md
# Configuration Word Stream Decoder

The block takes a stream of 32-bit configuration words, one word per cycle when `in_valid` is high. Until it has seen the alignment word `0xAA995566`, it discards everything, including the all-ones filler words that pad the start of a stream. Once aligned, it reads each word as a packet header. A header names a target register and gives a payload length. The payload words that follow are written into the block's own registers: command, frame length, option word, device identity, mask and frame address.

Payload words aimed at the frame-data register are not stored. Each one leaves the block on a strobed output, together with its index inside the packet. A long frame-data transfer uses a zero-length header followed by a second header that carries a 27-bit length.

The block also flags a full-device load. It raises two one-cycle command pulses, and it keeps sticky error flags for a bad header and for a device identity that does not match.

Top module: `cfg_stream_decoder`

## Requirements
- R1: After reset, `synced`, all six register outputs, `full_cfg`, `id_error`, `hdr_error`, `crc_reset`, `clk_switch`, `fd_valid` and `fd_count` are zero.
- R2: Before alignment, every accepted word other than `0xAA995566` (including `0xFFFFFFFF`) leaves all outputs unchanged.
- R3: The word `0xAA995566` received while unaligned sets `synced` one cycle later, and `synced` then stays high until reset.
- R4: An aligned word with bits[31:29]=001 and bits[28:27]=10 is a write header. Its register address is bits[17:13] and its length is bits[10:0]. The following length words are written to that register, and each value is visible one cycle after its word is accepted. The addresses are 4 command, 11 frame length, 9 options, 14 device identity, 6 mask, 1 frame address and 2 frame data.
- R5: A header with bits[31:29]=001 and bits[28:27]=00 is a no-op and changes nothing. A write header with length 0 only records its address.
- R6: An aligned word with bits[31:29]=010 is a long header. Its length, bits[26:0], applies to the address recorded by the most recent write header.
- R7: Each payload word for address 2 appears on `fd_word` with `fd_valid` high one cycle after it is accepted, with `fd_count` equal to its 0-based index in the packet. This happens only while the command register holds 1 and `id_error` is low; otherwise the word is consumed and not emitted.
- R8: After the last payload word of a packet, the next word is decoded as a header.
- R9: A device identity write whose value differs from parameter `EXP_ID` sets `id_error`, which stays set until reset. A matching value leaves it clear.
- R10: On each command write, `full_cfg` becomes 1 if the value is 1 and the frame address register is 0, and becomes 0 otherwise.
- R11: A command write of 7 pulses `crc_reset`, and a command write of 9 pulses `clk_switch`, each high for exactly one cycle.
- R12: An aligned header word matching neither the write, no-op nor long forms (for example bits[28:27]=01, or `0xFFFFFFFF`) sets `hdr_error`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word on `in_word` is accepted this cycle |
| in_word | input | 32 | Configuration stream word |
| synced | output | 1 | Alignment word has been seen |
| cfg_cmd | output | 32 | Command register |
| frame_len | output | 32 | Frame length register |
| cfg_opts | output | 32 | Option register |
| dev_id | output | 32 | Device identity register |
| cfg_mask | output | 32 | Mask register |
| frame_addr | output | 32 | Frame address register |
| crc_reset | output | 1 | One-cycle pulse on command 7 |
| clk_switch | output | 1 | One-cycle pulse on command 9 |
| full_cfg | output | 1 | Full-device load selected |
| id_error | output | 1 | Sticky device identity mismatch |
| hdr_error | output | 1 | Sticky malformed header |
| fd_valid | output | 1 | Frame-data word strobe |
| fd_word | output | 32 | Frame-data word |
| fd_count | output | CNT_W | Index of the word in its packet |

## Verification
The in-line properties check, on every cycle, these invariants:
- alignment never drops once set;
- nothing is emitted or flagged while unaligned;
- an emitted frame word always coincides with command 1 and no identity error;
- frame indices advance by one or restart at zero;
- both error flags are sticky;
- each command pulse matches the stored command.

Only the bench scenarios can show the following:
- that the header fields land in the right registers;
- that long headers use the recorded address;
- that packets end after exactly the right number of words;
- that filler words before alignment are truly harmless.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 5;
  localparam logic [WORD_W-1:0] SYNC_WORD = 32'hAA995566;

  localparam logic [ADDR_W-1:0] RA_FAR  = 5'd1;
  localparam logic [ADDR_W-1:0] RA_FDAT = 5'd2;
  localparam logic [ADDR_W-1:0] RA_CMD  = 5'd4;
  localparam logic [ADDR_W-1:0] RA_MASK = 5'd6;
  localparam logic [ADDR_W-1:0] RA_OPTS = 5'd9;
  localparam logic [ADDR_W-1:0] RA_FLEN = 5'd11;
  localparam logic [ADDR_W-1:0] RA_IDC  = 5'd14;

  localparam logic [WORD_W-1:0] CMD_WRCFG  = 32'd1;
  localparam logic [WORD_W-1:0] CMD_CRCRST = 32'd7;
  localparam logic [WORD_W-1:0] CMD_CLKSW  = 32'd9;

  typedef enum logic [1:0] {ST_HUNT, ST_HDR, ST_DATA} dec_state_e;
  typedef enum logic [1:0] {HK_WRITE, HK_NOP, HK_LONG, HK_BAD} hdr_kind_e;
endpackage

// File: rtl/cfg_hdr_decode.sv
module cfg_hdr_decode
  import cfg_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output hdr_kind_e         kind,
  output logic [ADDR_W-1:0] addr,
  output logic [10:0]       len_short,
  output logic [26:0]       len_long
);
  always_comb begin
    addr      = word[17:13];
    len_short = word[10:0];
    len_long  = word[26:0];
    kind      = HK_BAD;
    if (word[31:29] == 3'b001) begin
      if (word[28:27] == 2'b10)      kind = HK_WRITE;
      else if (word[28:27] == 2'b00) kind = HK_NOP;
    end else if (word[31:29] == 3'b010) begin
      kind = HK_LONG;
    end
  end
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_pkg::*;
#(
  parameter logic [WORD_W-1:0] EXP_ID = 32'h0140D093
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] cmd_q,
  output logic [WORD_W-1:0] flen_q,
  output logic [WORD_W-1:0] opts_q,
  output logic [WORD_W-1:0] idc_q,
  output logic [WORD_W-1:0] mask_q,
  output logic [WORD_W-1:0] far_q,
  output logic              crc_rst_p,
  output logic              clk_sw_p,
  output logic              full_q,
  output logic              id_err_q
);
  logic en_cmd, en_flen, en_opts, en_idc, en_mask, en_far;
  logic full_d, id_err_d, crc_d, clk_d;

  always_comb begin
    en_cmd   = wr_en && (wr_addr == RA_CMD);
    en_flen  = wr_en && (wr_addr == RA_FLEN);
    en_opts  = wr_en && (wr_addr == RA_OPTS);
    en_idc   = wr_en && (wr_addr == RA_IDC);
    en_mask  = wr_en && (wr_addr == RA_MASK);
    en_far   = wr_en && (wr_addr == RA_FAR);
    full_d   = en_cmd ? ((wr_data == CMD_WRCFG) && (far_q == '0)) : full_q;
    id_err_d = id_err_q || (en_idc && (wr_data != EXP_ID));
    crc_d    = en_cmd && (wr_data == CMD_CRCRST);
    clk_d    = en_cmd && (wr_data == CMD_CLKSW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; flen_q <= '0; opts_q <= '0;
      idc_q <= '0; mask_q <= '0; far_q  <= '0;
      full_q <= 1'b0; id_err_q <= 1'b0;
      crc_rst_p <= 1'b0; clk_sw_p <= 1'b0;
    end else begin
      if (en_cmd)  cmd_q  <= wr_data;
      if (en_flen) flen_q <= wr_data;
      if (en_opts) opts_q <= wr_data;
      if (en_idc)  idc_q  <= wr_data;
      if (en_mask) mask_q <= wr_data;
      if (en_far)  far_q  <= wr_data;
      full_q    <= full_d;
      id_err_q  <= id_err_d;
      crc_rst_p <= crc_d;
      clk_sw_p  <= clk_d;
    end
  end

  AST_ID_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    id_err_q |=> id_err_q); // R9
  AST_CRC_PULSE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    crc_rst_p |-> (cmd_q == CMD_CRCRST) && !clk_sw_p); // R11
  AST_CLK_PULSE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sw_p |-> (cmd_q == CMD_CLKSW)); // R11
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    crc_rst_p |=> !crc_rst_p); // R11
endmodule

// File: rtl/cfg_stream_decoder.sv
module cfg_stream_decoder
  import cfg_pkg::*;
#(
  parameter logic [31:0] EXP_ID = 32'h0140D093,
  parameter int          CNT_W  = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      in_word,
  output logic             synced,
  output logic [31:0]      cfg_cmd,
  output logic [31:0]      frame_len,
  output logic [31:0]      cfg_opts,
  output logic [31:0]      dev_id,
  output logic [31:0]      cfg_mask,
  output logic [31:0]      frame_addr,
  output logic             crc_reset,
  output logic             clk_switch,
  output logic             full_cfg,
  output logic             id_error,
  output logic             hdr_error,
  output logic             fd_valid,
  output logic [31:0]      fd_word,
  output logic [CNT_W-1:0] fd_count
);
  localparam int SHORT_W = 11;

  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  hdr_kind_e         h_kind;
  logic [ADDR_W-1:0] h_addr;
  logic [10:0]       h_len_s;
  logic [26:0]       h_len_l;

  cfg_hdr_decode u_hdr (
    .word(in_word), .kind(h_kind), .addr(h_addr),
    .len_short(h_len_s), .len_long(h_len_l)
  );

  dec_state_e        st_q, st_d;
  logic [CNT_W-1:0]  rem_q, rem_d, idx_q, idx_d, fdc_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              herr_q, herr_d, fdv_d, wr_en, fd_ok;
  logic [31:0]       fdw_d;

  always_comb begin
    st_d   = st_q;
    rem_d  = rem_q;
    idx_d  = idx_q;
    addr_d = addr_q;
    herr_d = herr_q;
    fdv_d  = 1'b0;
    fdw_d  = fd_word;
    fdc_d  = fd_count;
    wr_en  = 1'b0;
    fd_ok  = (cfg_cmd == CMD_WRCFG) && !id_error;
    if (in_valid) begin
      unique case (st_q)
        ST_HUNT: if (in_word == SYNC_WORD) st_d = ST_HDR;
        ST_HDR: begin
          unique case (h_kind)
            HK_WRITE: begin
              addr_d = h_addr;
              if (h_len_s != '0) begin
                rem_d = CNT_W'(h_len_s);
                idx_d = '0;
                st_d  = ST_DATA;
              end
            end
            HK_LONG: begin
              if (h_len_l[CNT_W-1:0] != '0) begin
                rem_d = h_len_l[CNT_W-1:0];
                idx_d = '0;
                st_d  = ST_DATA;
              end
            end
            HK_NOP: ;
            default: herr_d = 1'b1;
          endcase
        end
        ST_DATA: begin
          wr_en = (addr_q != RA_FDAT);
          if ((addr_q == RA_FDAT) && fd_ok) begin
            fdv_d = 1'b1;
            fdw_d = in_word;
            fdc_d = idx_q;
          end
          idx_d = idx_q + 1'b1;
          rem_d = rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) st_d = ST_HDR;
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q     <= ST_HUNT;
      rem_q    <= '0;
      idx_q    <= '0;
      addr_q   <= '0;
      herr_q   <= 1'b0;
      fd_valid <= 1'b0;
      fd_word  <= '0;
      fd_count <= '0;
    end else begin
      st_q     <= st_d;
      rem_q    <= rem_d;
      idx_q    <= idx_d;
      addr_q   <= addr_d;
      herr_q   <= herr_d;
      fd_valid <= fdv_d;
      fd_word  <= fdw_d;
      fd_count <= fdc_d;
    end
  end

  assign synced    = (st_q != ST_HUNT);
  assign hdr_error = herr_q;

  cfg_regbank #(.EXP_ID(EXP_ID)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .wr_en(wr_en), .wr_addr(addr_q), .wr_data(in_word),
    .cmd_q(cfg_cmd), .flen_q(frame_len), .opts_q(cfg_opts), .idc_q(dev_id),
    .mask_q(cfg_mask), .far_q(frame_addr), .crc_rst_p(crc_reset),
    .clk_sw_p(clk_switch), .full_q(full_cfg), .id_err_q(id_error)
  );

  AST_SYNC_HOLDS: assert property (@(posedge clk) disable iff (!rst_s_n)
    synced |=> synced); // R3
  AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_s_n)
    !synced |-> !fd_valid && !hdr_error && !crc_reset && !clk_switch); // R2
  AST_FD_GATED: assert property (@(posedge clk) disable iff (!rst_s_n)
    fd_valid |-> (cfg_cmd == CMD_WRCFG) && !id_error); // R7
  AST_FD_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_s_n)
    fd_valid && $past(fd_valid) |-> (fd_count == $past(fd_count) + 1'b1) || (fd_count == '0)); // R7
  AST_HDR_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_s_n)
    hdr_error |=> hdr_error); // R12
  AST_SHORT_FITS: assert property (@(posedge clk) disable iff (!rst_s_n)
    synced |-> (CNT_W >= SHORT_W)); // R4
endmodule

// File: tb/cfg_stream_decoder_bench.sv
module cfg_stream_decoder_bench;
  localparam logic [31:0] EXP = 32'h0140D093;
  localparam int CW = 27;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic synced, crc_reset, clk_switch, full_cfg, id_error, hdr_error, fd_valid;
  logic [31:0] cfg_cmd, frame_len, cfg_opts, dev_id, cfg_mask, frame_addr, fd_word;
  logic [CW-1:0] fd_count;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfg_stream_decoder #(.EXP_ID(EXP), .CNT_W(CW)) u_cfg_stream_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .synced(synced), .cfg_cmd(cfg_cmd), .frame_len(frame_len), .cfg_opts(cfg_opts),
    .dev_id(dev_id), .cfg_mask(cfg_mask), .frame_addr(frame_addr),
    .crc_reset(crc_reset), .clk_switch(clk_switch), .full_cfg(full_cfg),
    .id_error(id_error), .hdr_error(hdr_error), .fd_valid(fd_valid),
    .fd_word(fd_word), .fd_count(fd_count)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w);
    in_word = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [31:0] whdr(input int addr, input int len);
    return 32'h30000000 | (32'(addr) << 13) | 32'(len);
  endfunction

  task automatic wreg(input int addr, input logic [31:0] v);
    send(whdr(addr, 1));
    send(v);
  endtask

  task automatic sync_up();
    do_reset();
    send(32'hFFFFFFFF);
    send(32'hAA995566);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 synced", 32'(synced), 0);
    chk("R1 regs", cfg_cmd | frame_len | cfg_opts | dev_id | cfg_mask | frame_addr, 0);
    chk("R1 flags", {26'd0, full_cfg, id_error, hdr_error, fd_valid, crc_reset, clk_switch}, 0);
    chk("R1 fd_count", 32'(fd_count), 0);

    // R2, R3: sweep of filler counts before alignment
    for (int nd = 0; nd < 5; nd++) begin
      do_reset();
      for (int k = 0; k < nd; k++) send(32'hFFFFFFFF);
      send(whdr(6, 1)); send(32'h1234);
      chk("R2 ignored pre-sync", {cfg_mask[29:0], synced, hdr_error}, 0);
      send(32'hAA995566);
      chk("R3 synced", 32'(synced), 1);
      wreg(6, 32'h1000 + 32'(nd));
      chk("R4 mask after sync", cfg_mask, 32'h1000 + 32'(nd));
      chk("R3 still synced", 32'(synced), 1);
    end

    // R4 every register address
    sync_up();
    wreg(11, 32'h24);        chk("R4 frame_len", frame_len, 32'h24);
    wreg(9, 32'hA5000009);   chk("R4 opts", cfg_opts, 32'hA5000009);
    wreg(14, EXP);           chk("R4 dev_id", dev_id, EXP);
    chk("R9 match no error", 32'(id_error), 0);
    wreg(6, 32'hA5000006);   chk("R4 mask", cfg_mask, 32'hA5000006);
    wreg(1, 32'h5);          chk("R4 frame_addr", frame_addr, 32'h5);
    wreg(4, 32'd1);          chk("R4 cmd", cfg_cmd, 1);
    chk("R10 far nonzero", 32'(full_cfg), 0);

    // R5 no-op and zero-length headers
    send(32'h20000000);
    chk("R5 nop", {cfg_mask, 31'd0, hdr_error} == {32'hA5000006, 32'd0} ? 1 : 0, 1);
    send(whdr(6, 0));
    send(32'h40000001); send(32'h77);
    chk("R6 long header to recorded mask", cfg_mask, 32'h77);

    // R11 command pulses
    send(whdr(4, 1)); send(32'd7);
    chk("R11 crc pulse", {crc_reset, clk_switch}, 2'b10);
    @(negedge clk);
    chk("R11 crc pulse one cycle", 32'(crc_reset), 0);
    send(whdr(4, 1)); send(32'd9);
    chk("R11 clk pulse", {crc_reset, clk_switch}, 2'b01);
    @(negedge clk);
    chk("R11 clk pulse one cycle", 32'(clk_switch), 0);

    // R7 frame data while command is not 1: consumed silently
    send(32'h30004000); send(32'h40000002);
    send(32'hDEAD0000); chk("R7 gated by cmd", 32'(fd_valid), 0);
    send(32'hDEAD0001); chk("R7 gated by cmd", 32'(fd_valid), 0);
    wreg(6, 32'h88); chk("R8 header after gated data", cfg_mask, 32'h88);

    // R10 full configuration
    wreg(1, 32'h0); wreg(4, 32'd1);
    chk("R10 full_cfg", 32'(full_cfg), 1);

    // R6, R7, R8 frame-data length sweep
    for (int n = 1; n <= 6; n++) begin
      send(32'h30004000);
      send(32'h50000000 | 32'(n));
      for (int k = 0; k < n; k++) begin
        send(32'(n * 256 + k));
        chk("R7 fd_valid", 32'(fd_valid), 1);
        chk("R7 fd_word", fd_word, 32'(n * 256 + k));
        chk("R7 fd_count", 32'(fd_count), 32'(k));
      end
      wreg(6, 32'h900 + 32'(n));
      chk("R8 back to header", cfg_mask, 32'h900 + 32'(n));
      chk("R7 no stray strobe", 32'(fd_valid), 0);
    end

    // R4 short frame-data header with direct length
    send(32'h30004003);
    for (int k = 0; k < 3; k++) begin
      send(32'hC0 + 32'(k));
      chk("R4 short fd word", {fd_valid, fd_word[30:0]}, 32'h80000000 | (32'hC0 + 32'(k)));
    end
    // R8 multi-word register write, last wins
    send(whdr(6, 2)); send(32'hB1); send(32'hB2);
    chk("R8 multiword mask", cfg_mask, 32'hB2);
    wreg(9, 32'hB3); chk("R8 header after multiword", cfg_opts, 32'hB3);

    // R9 identity mismatch blocks frame data
    wreg(14, EXP ^ 32'h1);
    chk("R9 id_error set", 32'(id_error), 1);
    wreg(4, 32'd1);
    send(32'h30004002);
    send(32'hE0); chk("R7 gated by id", 32'(fd_valid), 0);
    send(32'hE1); chk("R7 gated by id", 32'(fd_valid), 0);
    wreg(14, EXP);
    chk("R9 sticky", 32'(id_error), 1);

    // R12 malformed headers
    sync_up();
    send(32'h28008001);
    chk("R12 read op", 32'(hdr_error), 1);
    sync_up();
    chk("R12 clear after reset", 32'(hdr_error), 0);
    send(32'hFFFFFFFF);
    chk("R12 filler after sync", 32'(hdr_error), 1);
    send(32'h20000000);
    chk("R12 sticky", 32'(hdr_error), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule